// File: doc/BRIEF.md
# EEPROM Status and Write-Protect Unit

This unit holds the status register of a serial EEPROM and makes every accept or reject decision for array writes and status writes. A command decoder upstream turns the serial stream into single-cycle events: write enable, write disable, a committed status write with its data byte, a committed array write with its target address, and the end of the self-timed programming cycle. The unit also watches the level of the active-low write-protect pin.

It presents the status byte that a status read shifts out. Each committed command gets a same-cycle accept strobe, and a busy flag stays high while a programming cycle runs. The two block-protect bits select how much of the top of the array is locked. A status write does not change them at once: it stages the new value, which takes effect only when the programming cycle finishes. This keeps the value that is read back steady for the whole cycle. The unit does no serial shifting and holds no array data.

Top module: `eeprom_status_unit`

## Requirements
- R1: The status byte reads bits 7..4 as 1, bit 3 as protect bit high (bpHi), bit 2 as protect bit low (bpLo), bit 1 as the write-enable latch (WEL) and bit 0 as write-in-progress (WIP).
- R2: After power-on reset (rstN low) the status byte is 8'hF0: protect bits 00, WEL 0, WIP 0, and busy is 0.
- R3: A write-enable event sets WEL on the next clock edge if wpN is high. A write-disable event clears WEL on the next clock edge.
- R4: While wpN is low, WEL is cleared on every clock edge, and a write-enable event leaves it at 0.
- R5: An array write or status write is accepted (same-cycle accept strobe) only when WEL is 1, WIP is 0 and wpN is high. An accepted command sets WIP and busy on the next edge. A rejected command changes no status bit.
- R6: With ADDR_W=9 and protect bits {bpHi,bpLo}, an array write is rejected for these target addresses: none for 00, 384..511 for 01, 256..511 for 10, and every address for 11.
- R7: An accepted status write takes only data bits 3:2 into the protect bits. Data bits 7..4, 1 and 0 have no effect on the status byte.
- R8: While a cycle runs, status bits 3:2 keep the value they had when it started. A staged protect value appears on the edge that ends the cycle.
- R9: A cycle-done event while WIP is 1 clears WIP and WEL on the next edge. A cycle-done event while WIP is 0 has no effect.
- R10: Once started, a cycle keeps WIP at 1 until cycle-done. A write-disable event, a low wpN or a soft reset does not end it.
- R11: A soft reset (softRst high for a cycle) clears WEL and leaves the protect bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| softRst | input | 1 | Synchronous soft reset pulse |
| wpN | input | 1 | Write-protect pin level, active low |
| evWren | input | 1 | Write-enable event |
| evWrdi | input | 1 | Write-disable event |
| evWrsr | input | 1 | Committed status-write event |
| wrsrData | input | 8 | Data byte of the status write |
| evWrite | input | 1 | Committed array-write event |
| tgtAddr | input | ADDR_W | Target address of the array write |
| cycleDone | input | 1 | Self-timed programming cycle finished |
| statusByte | output | 8 | Current status byte |
| writeAccept | output | 1 | Array write accepted this cycle |
| wrsrAccept | output | 1 | Status write accepted this cycle |
| busy | output | 1 | Programming cycle in progress |

## Verification
A bad WEL or WIP register shows up on status bits 1:0 one edge after the event that corrupted it. It also shows up at once in the accept strobes of the next committed command. A wrong protect comparator or a wrong staged protect value shows only on a later array write. For that reason every address is tried under each of the four protect settings, and the accept strobe is compared in the same cycle. The frozen-read rule is checked by reading bits 3:2 during the cycle and again on the edge after cycle-done, where a premature copy would already differ.

// File: rtl/eesu_pkg.sv
`timescale 1ns/1ps
package eesu_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic startCyc;
    logic cycIsStatus;
    logic endCyc;
  } eesu_strobe_t;

  localparam logic [3:0] STATUS_ONES = 4'hF;
  localparam int BP_LSB = 2;
endpackage

// File: rtl/eesu_region_cmp.sv
`timescale 1ns/1ps
module eesu_region_cmp #(
  parameter int ADDR_W = 9
) (
  input  logic [1:0]        bpSel,
  input  logic [ADDR_W-1:0] addr,
  output logic              isLocked
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] QUARTER_BASE = (ADDR_W+1)'(DEPTH - DEPTH / 4);
  localparam logic [ADDR_W:0] HALF_BASE    = (ADDR_W+1)'(DEPTH / 2);

  logic [ADDR_W:0] addrExt;
  assign addrExt = {1'b0, addr};

  always_comb begin
    unique case (bpSel)
      2'b00:   isLocked = 1'b0;
      2'b01:   isLocked = (addrExt >= QUARTER_BASE);
      2'b10:   isLocked = (addrExt >= HALF_BASE);
      default: isLocked = 1'b1;
    endcase
  end
endmodule

// File: rtl/eesu_ctrl.sv
`timescale 1ns/1ps
module eesu_ctrl
  import eesu_pkg::*;
(
  input  logic         softRst,
  input  logic         wpN,
  input  logic         evWren,
  input  logic         evWrdi,
  input  logic         evWrsr,
  input  logic         evWrite,
  input  logic         cycleDone,
  input  logic         welNow,
  input  logic         wipNow,
  input  logic         addrLocked,
  output eesu_strobe_t strobe,
  output logic         writeOk,
  output logic         wrsrOk
);
  logic gateOpen;

  // Shared gate for both non-volatile commands.
  assign gateOpen = welNow && !wipNow && wpN;
  assign writeOk  = evWrite && gateOpen && !addrLocked;
  assign wrsrOk   = evWrsr  && gateOpen;

  always_comb begin
    strobe             = '0;
    strobe.endCyc      = cycleDone && wipNow;
    strobe.startCyc    = writeOk || wrsrOk;
    strobe.cycIsStatus = wrsrOk;
    strobe.setWel      = evWren && wpN;
    strobe.clrWel      = !wpN || evWrdi || softRst || strobe.endCyc;
  end
endmodule

// File: rtl/eesu_datapath.sv
`timescale 1ns/1ps
module eesu_datapath
  import eesu_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  eesu_strobe_t strobe,
  input  logic [7:0]   wrsrData,
  output logic         welNow,
  output logic         wipNow,
  output logic [1:0]   bpNow,
  output logic [7:0]   statusByte
);
  logic [1:0] bpStaged;
  logic       cycKindStatus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welNow <= 1'b0;
    end else if (strobe.clrWel) begin
      welNow <= 1'b0;
    end else if (strobe.setWel) begin
      welNow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wipNow        <= 1'b0;
      cycKindStatus <= 1'b0;
      bpStaged      <= 2'b00;
    end else if (strobe.startCyc) begin
      wipNow        <= 1'b1;
      cycKindStatus <= strobe.cycIsStatus;
      if (strobe.cycIsStatus) bpStaged <= wrsrData[BP_LSB+1:BP_LSB];
    end else if (strobe.endCyc) begin
      wipNow <= 1'b0;
    end
  end

  // Protect bits change only at the end of a status-write cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpNow <= 2'b00;
    end else if (strobe.endCyc && cycKindStatus) begin
      bpNow <= bpStaged;
    end
  end

  assign statusByte = {STATUS_ONES, bpNow, welNow, wipNow};
endmodule

// File: rtl/eeprom_status_unit.sv
`timescale 1ns/1ps
module eeprom_status_unit
  import eesu_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              wpN,
  input  logic              evWren,
  input  logic              evWrdi,
  input  logic              evWrsr,
  input  logic [7:0]        wrsrData,
  input  logic              evWrite,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic              cycleDone,
  output logic [7:0]        statusByte,
  output logic              writeAccept,
  output logic              wrsrAccept,
  output logic              busy
);
  eesu_strobe_t strobe;
  logic welNow, wipNow, addrLocked;
  logic [1:0] bpNow;

  eesu_region_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .bpSel(bpNow), .addr(tgtAddr), .isLocked(addrLocked)
  );

  eesu_ctrl u_ctrl (
    .softRst(softRst), .wpN(wpN), .evWren(evWren), .evWrdi(evWrdi),
    .evWrsr(evWrsr), .evWrite(evWrite), .cycleDone(cycleDone),
    .welNow(welNow), .wipNow(wipNow), .addrLocked(addrLocked),
    .strobe(strobe), .writeOk(writeAccept), .wrsrOk(wrsrAccept)
  );

  eesu_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrsrData(wrsrData),
    .welNow(welNow), .wipNow(wipNow), .bpNow(bpNow), .statusByte(statusByte)
  );

  assign busy = wipNow;
endmodule

// File: rtl/eesu_checker.sv
`timescale 1ns/1ps
module eesu_checker #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              softRst,
  input logic              wpN,
  input logic              evWrdi,
  input logic              cycleDone,
  input logic [7:0]        statusByte,
  input logic              writeAccept,
  input logic              wrsrAccept,
  input logic              busy
);
  p_ones_r1: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7:4] == 4'hF);

  p_wp_clears_wel_r4: assert property (@(posedge clk) disable iff (!rstN)
    !wpN |=> !statusByte[1]);

  p_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (writeAccept || wrsrAccept) |-> (statusByte[1] && !busy && wpN));

  p_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (writeAccept || wrsrAccept) |=> busy);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(statusByte[3:2]));

  p_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cycleDone) |=> (!busy && !statusByte[1]));

  p_no_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cycleDone) |=> busy);

  p_soft_r11: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && !busy) |=> (!statusByte[1] && $stable(statusByte[3:2])));

  p_wip_bit_r1: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[0] == busy);
endmodule

bind eeprom_status_unit eesu_checker #(.ADDR_W(ADDR_W)) u_eesu_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .wpN(wpN), .evWrdi(evWrdi),
  .cycleDone(cycleDone), .statusByte(statusByte), .writeAccept(writeAccept),
  .wrsrAccept(wrsrAccept), .busy(busy)
);

// File: tb/eeprom_status_unit_bench.sv
`timescale 1ns/1ps
module eeprom_status_unit_bench;
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN, softRst, wpN, evWren, evWrdi, evWrsr, evWrite, cycleDone;
  logic [7:0] wrsrData;
  logic [ADDR_W-1:0] tgtAddr;
  logic [7:0] statusByte;
  logic writeAccept, wrsrAccept, busy;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  logic finished = 1'b0;
  logic accW, accS;

  always #2 clk = ~clk;

  eeprom_status_unit #(.ADDR_W(ADDR_W)) u_eeprom_status_unit (
    .clk(clk), .rstN(rstN), .softRst(softRst), .wpN(wpN), .evWren(evWren),
    .evWrdi(evWrdi), .evWrsr(evWrsr), .wrsrData(wrsrData), .evWrite(evWrite),
    .tgtAddr(tgtAddr), .cycleDone(cycleDone), .statusByte(statusByte),
    .writeAccept(writeAccept), .wrsrAccept(wrsrAccept), .busy(busy)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    evWren = 0; evWrdi = 0; evWrsr = 0; evWrite = 0; cycleDone = 0; softRst = 0;
  endtask

  // One-cycle event: drive after a falling edge, capture accepts, clear at next falling edge.
  task automatic pulse(input logic wren, input logic wrdi, input logic wrsr, input logic [7:0] d,
                       input logic wr, input logic [ADDR_W-1:0] a, input logic done, input logic sr);
    @(negedge clk);
    evWren = wren; evWrdi = wrdi; evWrsr = wrsr; wrsrData = d;
    evWrite = wr; tgtAddr = a; cycleDone = done; softRst = sr;
    #1;
    accW = writeAccept; accS = wrsrAccept;
    @(negedge clk);
    idle();
  endtask

  task automatic wren();              pulse(1,0,0,8'h00,0,'0,0,0); endtask
  task automatic wrdi();              pulse(0,1,0,8'h00,0,'0,0,0); endtask
  task automatic wrsr(input logic [7:0] d); pulse(0,0,1,d,0,'0,0,0); endtask
  task automatic wr(input logic [ADDR_W-1:0] a); pulse(0,0,0,8'h00,1,a,0,0); endtask
  task automatic done();              pulse(0,0,0,8'h00,0,'0,1,0); endtask
  task automatic sreset();            pulse(0,0,0,8'h00,0,'0,0,1); endtask

  function automatic logic lockedExp(input int bp, input int a);
    case (bp)
      0: return 1'b0;
      1: return a >= (DEPTH * 3) / 4;
      2: return a >= DEPTH / 2;
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(); wrsrData = 0; tgtAddr = 0; wpN = 1; rstN = 0;
    repeat (3) @(negedge clk);
    check("R2 reset status", statusByte, 8'hF0);
    check("R2 reset busy", {7'b0, busy}, 8'h00);
    rstN = 1;
    @(negedge clk);

    wren();  check("R3 wren sets WEL", statusByte, 8'hF2);
    wrdi();  check("R3 wrdi clears WEL", statusByte, 8'hF0);

    wrsr(8'h0C); check("R5 wrsr rejected without WEL", {7'b0, accS}, 8'h00);
    check("R5 no change after reject", statusByte, 8'hF0);
    wr(9'h000);  check("R5 write rejected without WEL", {7'b0, accW}, 8'h00);

    // R4: pin low clears WEL and blocks wren and commands
    wren();
    @(negedge clk); wpN = 0;
    @(negedge clk);
    check("R4 pin low clears WEL", statusByte, 8'hF0);
    wren();  check("R4 wren ignored with pin low", statusByte, 8'hF0);
    wrsr(8'h0C); check("R4 wrsr rejected with pin low", {7'b0, accS}, 8'h00);
    wpN = 1;

    // R7/R8: status write with all bits set, only bits 3:2 land, frozen until done
    wren();
    wrsr(8'hF3 | 8'h08); check("R5 wrsr accepted", {7'b0, accS}, 8'h01);
    check("R8 bp frozen, WIP set", statusByte, 8'hF3);
    wr(9'h000); check("R5 write rejected while busy", {7'b0, accW}, 8'h00);
    wrsr(8'h0C); check("R5 wrsr rejected while busy", {7'b0, accS}, 8'h00);
    wrdi();  check("R10 wrdi live, cycle kept", statusByte, 8'hF1);
    wren();  check("R3 WEL live during cycle", statusByte, 8'hF3);
    sreset(); check("R10 soft reset keeps cycle", statusByte, 8'hF1);
    @(negedge clk); wpN = 0;
    repeat (3) @(negedge clk);
    check("R10 pin low does not abort", statusByte, 8'hF1);
    wpN = 1;
    wren();
    done();  check("R7 R8 R9 bp applied, WEL and WIP cleared", statusByte, 8'hF8);
    done();  check("R9 stray done no effect", statusByte, 8'hF8);

    // R11: soft reset keeps protect bits
    wren(); sreset(); check("R11 soft reset", statusByte, 8'hF8);

    // R6: full sweep of protect settings and addresses
    for (int bp = 0; bp < 4; bp++) begin
      wren(); wrsr(8'(bp << 2)); done();
      check("R6 bp setting", statusByte, 8'hF0 | 8'(bp << 2));
      for (int a = 0; a < DEPTH; a++) begin
        wren();
        wr(ADDR_W'(a));
        check($sformatf("R6 bp=%0d addr=%0d", bp, a), {7'b0, accW}, {7'b0, !lockedExp(bp, a)});
        if (accW) begin
          if (a == 5) check("R5 write starts cycle", statusByte, 8'hF3 | 8'(bp << 2));
          done();
          if (a == 5) check("R9 write done clears WEL", statusByte, 8'hF0 | 8'(bp << 2));
        end else begin
          check($sformatf("R5 reject keeps status bp=%0d", bp), statusByte, 8'hF2 | 8'(bp << 2));
          wrdi();
        end
      end
    end

    // R2: power-on reset returns protect bits to 00
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    check("R2 power-on clears bp", statusByte, 8'hF0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule